// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block searches for the divider settings of a frequency synthesizer. Its output frequency is ref × N / (M × P), where P is a post-divider value picked from an eight-entry table by index D. Given a reference frequency (a numerator and a denominator), a target pixel clock in kHz and a ceiling on the undivided oscillator frequency, it walks every reference divider M within the configured range and every post-divider index. For each point it derives a feedback divider N and keeps the setting whose synthesized frequency lies closest to the target.

A single shared iterative divider does all the arithmetic, so a search takes roughly one hundred cycles per (M, D) point. Software or a mode-set sequencer pulses `start` and waits for `done`. It then reads N, M, D, the frequency those settings produce and a flag that says whether the result is usable. The limits on N and M, an offset on N, a granularity ratio on N, the choice of post-divider table and an integrated-oscillator mode are all inputs, so one instance can serve several synthesizer types.

Top module: `pll_div_search`

## Requirements
- R1: A `start` pulse while `busy` is low latches the inputs and begins a search. `busy` stays high until the search ends. `done` is then high for exactly one cycle, in the same cycle in which `busy` falls. A `start` while `busy` is high has no effect on the result.
- R2: M runs from `min_m` up to `max_m` inclusive (outer loop), and D runs from 0 to 7 for each M (inner loop). If `min_m` exceeds `max_m`, no point is evaluated. A point with M = 0 is skipped.
- R3: With `odd_div` = 0 the post-divider for index D is 2^D (1 to 128). With `odd_div` = 1 the table is 1, 2, 4, 8, 3, 0, 6, 12 for D = 0 to 7. An entry of 0 is never selected.
- R4: When `max_khz` is nonzero, a point whose floor(`max_khz` / P) is below `target_khz` is skipped. When `max_khz` is zero, no point is skipped for this reason.
- R5: Every division rounds to nearest, with halves rounded up. The raw N is round(target × M × `ref_den` × P / refnum), clamped into [`min_n`, `max_n`].
- R6: With offset o = `n_off` and granularity g = `gran_div` (0 treated as 1), h = `gran_mul`: q = N − o and lo = floor(q / g) × h. The first candidate is ceil((lo + 1) / g) + o when q > lo, and N otherwise. The second candidate, lo + o, is evaluated only when it is smaller than the first.
- R7: A candidate's frequency is round(N × refnum / (M × `ref_den` × P)), and its error is the absolute difference from the target. It replaces the kept setting when its error is smaller, or when the error is equal and its N is larger. Otherwise the earlier setting stays.
- R8: With `int_pll` = 1 the reference numerator is doubled before the search.
- R9: `synth_khz` is the kept frequency. `fail` is 1 when its distance from the target exceeds the parameter TOL_KHZ, or when no point was evaluated; in the latter case N, M, D and `synth_khz` are 0.
- R10: After reset all outputs are 0. After `done`, the outputs hold their values until the next accepted `start`, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (taken only when idle) |
| odd_div | input | 1 | Select the table with odd post-dividers |
| int_pll | input | 1 | Double the reference numerator |
| ref_num | input | RW | Reference frequency numerator, kHz |
| ref_den | input | DENW | Reference frequency denominator |
| target_khz | input | TW | Requested frequency, kHz |
| max_khz | input | TW | Oscillator ceiling, kHz; 0 disables the limit |
| min_m | input | MW | Lowest reference divider |
| max_m | input | MW | Highest reference divider |
| min_n | input | NW | Lowest feedback divider |
| max_n | input | NW | Highest feedback divider |
| n_off | input | NW | Offset removed before granularity rounding |
| gran_div | input | NW | Granularity divisor g |
| gran_mul | input | NW | Granularity multiplier h |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| n_out | output | NW | Chosen feedback divider |
| m_out | output | MW | Chosen reference divider |
| d_out | output | 3 | Chosen post-divider index |
| synth_khz | output | TW | Frequency of the chosen setting (saturating) |
| fail | output | 1 | Result outside tolerance or nothing evaluated |

## Verification
The hardest case to reach from the ports is the tie rule: several (M, D) points giving exactly the same error, with the winner decided by N and then by search order. The stimulus reaches it by choosing a target that is an exact integer multiple of the reference over a power of two. Many points then synthesize it with zero error, and only the largest feasible N, found first, should survive. Sweeps over a small limit set compare every output against a bench-side search. Separate runs pile up skip conditions until nothing is evaluated, and inject a second `start` mid-search.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_POINT, S_NWAIT, S_CA, S_CAWAIT, S_CB, S_CBWAIT, S_STEP, S_FIN
  } pds_state_e;

  // post-divider value for a table index; 0 marks an unusable slot
  function automatic logic [7:0] pd_value(input logic odd_sel, input logic [2:0] idx);
    logic [7:0] v;
    if (!odd_sel) begin
      v = 8'd1 << idx;
    end else begin
      case (idx)
        3'd0: v = 8'd1;
        3'd1: v = 8'd2;
        3'd2: v = 8'd4;
        3'd3: v = 8'd8;
        3'd4: v = 8'd3;
        3'd5: v = 8'd0;
        3'd6: v = 8'd6;
        default: v = 8'd12;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/pds_pdtab.sv
module pds_pdtab (
  input  logic       odd_sel,
  input  logic [2:0] idx,
  output logic [7:0] value
);
  always_comb value = pds_pkg::pd_value(odd_sel, idx);
endmodule

// File: rtl/pds_rdiv.sv
// Restoring divider, one quotient bit per cycle, round-half-up at the end.
module pds_rdiv #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         vld,
  output logic [W-1:0] quo
);
  localparam int CNTW = $clog2(W + 1);

  logic [W:0]      rem;
  logic [W-1:0]    qr;
  logic [W-1:0]    den_q;
  logic [CNTW-1:0] cnt;
  logic            run;

  logic [W:0] trial;
  logic       fits;
  logic       round_up;

  always_comb begin
    trial    = {rem[W-1:0], qr[W-1]};
    fits     = trial >= {1'b0, den_q};
    round_up = {rem[W-1:0], 1'b0} >= {1'b0, den_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      qr    <= '0;
      den_q <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      vld   <= 1'b0;
      quo   <= '0;
    end else begin
      vld <= 1'b0;
      if (go && !run) begin
        qr    <= num;
        den_q <= den;
        rem   <= '0;
        cnt   <= CNTW'(W);
        run   <= 1'b1;
      end else if (run) begin
        if (cnt != '0) begin
          rem <= fits ? (trial - {1'b0, den_q}) : trial;
          qr  <= {qr[W-2:0], fits};
          cnt <= cnt - 1'b1;
        end else begin
          quo <= qr + W'(round_up);
          vld <= 1'b1;
          run <= 1'b0;
        end
      end
    end
  end

  // R5: partial remainder stays below the divisor throughout
  p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && den_q != '0) |-> (rem < {1'b0, den_q}));

  p_vld_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);

endmodule

// File: rtl/pds_quant.sv
// Clamp a raw N and derive the one or two candidates after granularity rounding.
module pds_quant #(
  parameter int DW = 48,
  parameter int NW = 10
) (
  input  logic [DW-1:0]   nraw,
  input  logic [NW-1:0]   min_n,
  input  logic [NW-1:0]   max_n,
  input  logic [NW-1:0]   off,
  input  logic [NW-1:0]   g_div,
  input  logic [NW-1:0]   g_mul,
  output logic [NW+1:0]   cand_a,
  output logic [NW+1:0]   cand_b,
  output logic            two
);
  localparam int CW = NW + 2;

  logic [CW-1:0] n_cl, nq, g1e, lo, hi;

  always_comb begin
    if (nraw < DW'(min_n))      n_cl = CW'(min_n);
    else if (nraw > DW'(max_n)) n_cl = CW'(max_n);
    else                        n_cl = CW'(nraw[NW-1:0]);
    nq  = n_cl - CW'(off);
    g1e = (g_div == '0) ? CW'(1) : CW'(g_div);
    lo  = (nq / g1e) * CW'(g_mul);
    hi  = (nq > lo) ? ((lo + g1e) / g1e) : nq;
    cand_a = hi + CW'(off);
    cand_b = lo + CW'(off);
    two    = cand_a > cand_b;
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int TW      = 20,
  parameter int RW      = 20,
  parameter int DENW    = 8,
  parameter int MW      = 8,
  parameter int NW      = 10,
  parameter int TOL_KHZ = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            odd_div,
  input  logic            int_pll,
  input  logic [RW-1:0]   ref_num,
  input  logic [DENW-1:0] ref_den,
  input  logic [TW-1:0]   target_khz,
  input  logic [TW-1:0]   max_khz,
  input  logic [MW-1:0]   min_m,
  input  logic [MW-1:0]   max_m,
  input  logic [NW-1:0]   min_n,
  input  logic [NW-1:0]   max_n,
  input  logic [NW-1:0]   n_off,
  input  logic [NW-1:0]   gran_div,
  input  logic [NW-1:0]   gran_mul,
  output logic            busy,
  output logic            done,
  output logic [NW-1:0]   n_out,
  output logic [MW-1:0]   m_out,
  output logic [2:0]      d_out,
  output logic [TW-1:0]   synth_khz,
  output logic            fail
);
  import pds_pkg::*;

  localparam int PDW  = 8;
  localparam int CW   = NW + 2;
  localparam int DW_A = TW + MW + DENW + PDW;
  localparam int DW_B = CW + RW + 1;
  localparam int DIVW = (DW_A > DW_B) ? DW_A : DW_B;

  pds_state_e state;

  // latched configuration
  logic [TW-1:0]   tgt_q, mx_q;
  logic [RW:0]     ref_q;
  logic [DENW-1:0] den_q;
  logic            odd_q;
  logic [MW-1:0]   min_m_q, max_m_q;
  logic [NW-1:0]   min_n_q, max_n_q, off_q, g1_q, g2_q;

  // sweep state
  logic [MW-1:0]   m_cur;
  logic [2:0]      d_cur;
  logic [DIVW-1:0] mult_q, nraw_q;
  logic [CW-1:0]   ca_q, cb_q;
  logic            two_q;

  // kept result
  logic [DIVW-1:0] best_err, best_f;
  logic [CW-1:0]   best_n;
  logic [MW-1:0]   best_m;
  logic [2:0]      best_d;
  logic            found, fail_q, done_q;

  // named internal events
  logic [7:0]      pd_val;
  logic [DIVW-1:0] prod_mdp, n_num, pd_lim;
  logic            skip_pt, pt_accept;
  logic            div_go, div_vld;
  logic [DIVW-1:0] div_num, div_den, div_quo;
  logic [CW-1:0]   q_a, q_b;
  logic            q_two;
  logic [CW-1:0]   cur_n;
  logic [DIVW-1:0] cand_err, fin_gap;
  logic            cand_eval, cand_take;
  logic            last_d, last_m;

  pds_pdtab u_tab (
    .odd_sel (odd_q),
    .idx     (d_cur),
    .value   (pd_val)
  );

  pds_quant #(.DW(DIVW), .NW(NW)) u_quant (
    .nraw   (nraw_q),
    .min_n  (min_n_q),
    .max_n  (max_n_q),
    .off    (off_q),
    .g_div  (g1_q),
    .g_mul  (g2_q),
    .cand_a (q_a),
    .cand_b (q_b),
    .two    (q_two)
  );

  pds_rdiv #(.W(DIVW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (div_num),
    .den   (div_den),
    .vld   (div_vld),
    .quo   (div_quo)
  );

  function automatic logic [DIVW-1:0] abs_diff(input logic [DIVW-1:0] a, input logic [DIVW-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  always_comb begin
    prod_mdp  = DIVW'(m_cur) * DIVW'(den_q) * DIVW'(pd_val);
    n_num     = DIVW'(tgt_q) * prod_mdp;
    pd_lim    = DIVW'(tgt_q) * DIVW'(pd_val);
    skip_pt   = (pd_val == '0) || (m_cur == '0) ||
                ((mx_q != '0) && (DIVW'(mx_q) < pd_lim));
    pt_accept = (state == S_POINT) && !skip_pt;

    div_go  = pt_accept || (state == S_CA) || (state == S_CB);
    div_num = n_num;
    div_den = DIVW'(ref_q);
    if (state == S_CA) begin
      div_num = DIVW'(q_a) * DIVW'(ref_q);
      div_den = mult_q;
    end else if (state == S_CB) begin
      div_num = DIVW'(cb_q) * DIVW'(ref_q);
      div_den = mult_q;
    end

    cur_n     = (state == S_CBWAIT) ? cb_q : ca_q;
    cand_eval = div_vld && ((state == S_CAWAIT) || (state == S_CBWAIT));
    cand_err  = abs_diff(div_quo, DIVW'(tgt_q));
    cand_take = cand_eval &&
                ((cand_err < best_err) || ((cand_err == best_err) && (cur_n > best_n)));

    last_d  = (d_cur == 3'd7);
    last_m  = (m_cur == max_m_q);
    fin_gap = abs_diff(best_f, DIVW'(tgt_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tgt_q    <= '0;
      mx_q     <= '0;
      ref_q    <= '0;
      den_q    <= '0;
      odd_q    <= 1'b0;
      min_m_q  <= '0;
      max_m_q  <= '0;
      min_n_q  <= '0;
      max_n_q  <= '0;
      off_q    <= '0;
      g1_q     <= '0;
      g2_q     <= '0;
      m_cur    <= '0;
      d_cur    <= '0;
      mult_q   <= '0;
      nraw_q   <= '0;
      ca_q     <= '0;
      cb_q     <= '0;
      two_q    <= 1'b0;
      best_err <= '0;
      best_f   <= '0;
      best_n   <= '0;
      best_m   <= '0;
      best_d   <= '0;
      found    <= 1'b0;
      fail_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            tgt_q    <= target_khz;
            mx_q     <= max_khz;
            ref_q    <= int_pll ? {ref_num, 1'b0} : {1'b0, ref_num};
            den_q    <= ref_den;
            odd_q    <= odd_div;
            min_m_q  <= min_m;
            max_m_q  <= max_m;
            min_n_q  <= min_n;
            max_n_q  <= max_n;
            off_q    <= n_off;
            g1_q     <= gran_div;
            g2_q     <= gran_mul;
            m_cur    <= min_m;
            d_cur    <= '0;
            best_err <= '1;
            best_f   <= '0;
            best_n   <= '0;
            best_m   <= '0;
            best_d   <= '0;
            found    <= 1'b0;
            state    <= (min_m > max_m) ? S_FIN : S_POINT;
          end
        end
        S_POINT: begin
          if (skip_pt) begin
            state <= S_STEP;
          end else begin
            mult_q <= prod_mdp;
            state  <= S_NWAIT;
          end
        end
        S_NWAIT: begin
          if (div_vld) begin
            nraw_q <= div_quo;
            state  <= S_CA;
          end
        end
        S_CA: begin
          ca_q  <= q_a;
          cb_q  <= q_b;
          two_q <= q_two;
          state <= S_CAWAIT;
        end
        S_CAWAIT: begin
          if (div_vld) state <= two_q ? S_CB : S_STEP;
        end
        S_CB: state <= S_CBWAIT;
        S_CBWAIT: begin
          if (div_vld) state <= S_STEP;
        end
        S_STEP: begin
          if (!last_d) begin
            d_cur <= d_cur + 3'd1;
            state <= S_POINT;
          end else if (!last_m) begin
            m_cur <= m_cur + 1'b1;
            d_cur <= '0;
            state <= S_POINT;
          end else begin
            state <= S_FIN;
          end
        end
        S_FIN: begin
          fail_q <= !found || (fin_gap > DIVW'(TOL_KHZ));
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase

      if (cand_take) begin
        best_err <= cand_err;
        best_f   <= div_quo;
        best_n   <= cur_n;
        best_m   <= m_cur;
        best_d   <= d_cur;
        found    <= 1'b1;
      end
    end
  end

  always_comb begin
    busy      = (state != S_IDLE);
    done      = done_q;
    fail      = fail_q;
    n_out     = best_n[NW-1:0];
    m_out     = best_m;
    d_out     = best_d;
    synth_khz = (best_f > DIVW'({TW{1'b1}})) ? {TW{1'b1}} : best_f[TW-1:0];
  end

  // R1: end-of-search pulse lasts a single cycle
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R1: latched target cannot move while a search runs
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(tgt_q));

  // R2: every visited point lies inside the M window
  p_m_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POINT) |-> (m_cur >= min_m_q && m_cur <= max_m_q));

  // R3: an accepted point never uses an empty table slot
  p_no_zero_pd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pt_accept |-> (pd_val != 8'd0));

  // R7: kept error never grows during a search
  p_err_monotone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> (best_err <= $past(best_err)));

  // R9: an empty search always reports failure
  p_fail_no_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !found) |-> fail_q);

  // R10: outputs are frozen while idle with no start
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !start) |=> $stable(best_n) && $stable(best_f));

endmodule

// File: tb/sim_pll_div_search.sv
`timescale 1ns/1ps
module sim_pll_div_search;
  localparam int TW = 18, RW = 16, DENW = 4, MW = 4, NW = 9, TOL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic odd_div = 1'b0, int_pll = 1'b0;
  logic [RW-1:0]   ref_num = 16'd14318;
  logic [DENW-1:0] ref_den = 4'd1;
  logic [TW-1:0]   target_khz = '0, max_khz = '0;
  logic [MW-1:0]   min_m = 4'd1, max_m = 4'd4;
  logic [NW-1:0]   min_n = 9'd4, max_n = 9'd200, n_off = '0, gran_div = 9'd1, gran_mul = 9'd1;
  logic busy, done, fail;
  logic [NW-1:0] n_out;
  logic [MW-1:0] m_out;
  logic [2:0]    d_out;
  logic [TW-1:0] synth_khz;

  int total = 0, bad = 0;
  longint cyc = 0;

  always #4 clk = ~clk;

  pll_div_search #(.TW(TW), .RW(RW), .DENW(DENW), .MW(MW), .NW(NW), .TOL_KHZ(TOL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .odd_div(odd_div), .int_pll(int_pll),
    .ref_num(ref_num), .ref_den(ref_den), .target_khz(target_khz), .max_khz(max_khz),
    .min_m(min_m), .max_m(max_m), .min_n(min_n), .max_n(max_n), .n_off(n_off),
    .gran_div(gran_div), .gran_mul(gran_mul), .busy(busy), .done(done),
    .n_out(n_out), .m_out(m_out), .d_out(d_out), .synth_khz(synth_khz), .fail(fail));

  function automatic longint rdn(longint a, longint b);
    return (2 * a + b) / (2 * b);
  endfunction

  function automatic longint tabv(bit odd, int i);
    longint o[8] = '{1, 2, 4, 8, 3, 0, 6, 12};
    return odd ? o[i] : (longint'(1) << i);
  endfunction

  longint e_n, e_m, e_d, e_f;
  bit     e_fail;

  task automatic model(input longint tgt);
    longint r, best, mul, nr, q, g, lo, hi, ca, cb, f, e, pd;
    bit fnd;
    longint cand[2];
    int nc_cnt;
    r = int_pll ? 2 * longint'(ref_num) : longint'(ref_num);
    best = 64'h7fffffffffffffff;
    e_n = 0; e_m = 0; e_d = 0; e_f = 0; fnd = 0;
    for (longint m = min_m; m <= max_m; m++) begin
      for (int d = 0; d < 8; d++) begin
        pd = tabv(odd_div, d);
        if (pd == 0 || m == 0) continue;
        if (max_khz != 0 && (longint'(max_khz) / pd) < tgt) continue;
        mul = m * ref_den * pd;
        nr = rdn(tgt * mul, r);
        if (nr < min_n) nr = min_n;
        if (nr > max_n) nr = max_n;
        q = nr - n_off;
        g = (gran_div == 0) ? 1 : gran_div;
        lo = (q / g) * gran_mul;
        hi = (q > lo) ? (lo + 1 + g - 1) / g : q;
        ca = hi + n_off; cb = lo + n_off;
        cand[0] = ca; cand[1] = cb;
        nc_cnt = (ca > cb) ? 2 : 1;
        for (int k = 0; k < nc_cnt; k++) begin
          f = rdn(cand[k] * r, mul);
          e = (f > tgt) ? f - tgt : tgt - f;
          if (e < best || (e == best && cand[k] > e_n)) begin
            best = e; e_n = cand[k]; e_m = m; e_d = d; e_f = f; fnd = 1;
          end
        end
      end
    end
    e_fail = !fnd || (((e_f > tgt) ? e_f - tgt : tgt - e_f) > TOL);
  endtask

  task automatic chk(input string req, input bit ok, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  task automatic launch();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic cmp(input string req);
    chk(req, n_out == e_n[NW-1:0] && m_out == e_m[MW-1:0] && d_out == e_d[2:0] &&
             synth_khz == e_f[TW-1:0] && fail == e_fail,
        $sformatf("act n=%0d m=%0d d=%0d f=%0d fail=%0b exp n=%0d m=%0d d=%0d f=%0d fail=%0b",
                  n_out, m_out, d_out, synth_khz, fail, e_n, e_m, e_d, e_f, e_fail));
  endtask

  task automatic search(input longint tgt, input string req);
    target_khz = tgt[TW-1:0];
    model(tgt);
    launch();
    wait_done();
    cmp(req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    longint tl[8] = '{25175, 31500, 40000, 50000, 65000, 75000, 94500, 108000};
    logic [NW-1:0] hn; logic [TW-1:0] hf;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", busy == 0 && done == 0 && n_out == 0 && m_out == 0 && d_out == 0 &&
              synth_khz == 0 && fail == 0,
        $sformatf("act busy=%0b n=%0d f=%0d exp all zero", busy, n_out, synth_khz));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R5 R7 R9: sweep of targets over the normal table
    foreach (tl[i]) search(tl[i], "R2/R5/R7");

    // R4: oscillator ceiling of 135 MHz
    max_khz = 18'd135000;
    search(40000, "R4");
    chk("R4", (135000 / tabv(0, d_out)) >= 40000, $sformatf("act d=%0d exp pd<=3", d_out));

    // R9: ceiling below every reachable point, nothing evaluated
    max_khz = 18'd10000;
    search(40000, "R9");
    chk("R9", fail == 1 && n_out == 0 && m_out == 0 && synth_khz == 0,
        $sformatf("act fail=%0b n=%0d exp fail=1 n=0", fail, n_out));
    max_khz = '0;

    // R3: odd table
    odd_div = 1'b1;
    search(47727, "R3");
    search(23864, "R3");
    chk("R3", d_out != 3'd5, $sformatf("act d=%0d exp not 5", d_out));
    odd_div = 1'b0;

    // R8: doubled reference
    int_pll = 1'b1;
    search(60000, "R8");
    search(125000, "R8");
    int_pll = 1'b0;

    // R6: granularity and offset
    gran_div = 9'd2; gran_mul = 9'd2; n_off = 9'd1;
    search(52000, "R6");
    gran_div = 9'd8; gran_mul = 9'd9; n_off = 9'd0; min_n = 9'd16;
    search(33000, "R6");
    gran_div = 9'd0; gran_mul = 9'd1;
    search(41000, "R6");
    gran_div = 9'd1; min_n = 9'd4;

    // R7: exact target, many zero-error ties; largest N first found wins
    search(71590, "R7");
    chk("R7", n_out == 160 && m_out == 1 && d_out == 5 && synth_khz == 71590,
        $sformatf("act n=%0d m=%0d d=%0d exp n=160 m=1 d=5", n_out, m_out, d_out));

    // R1: start during a search is ignored
    target_khz = 18'd56000;
    model(56000);
    launch();
    repeat (100) @(negedge clk);
    chk("R1", busy == 1, $sformatf("act busy=%0b exp 1", busy));
    target_khz = 18'd99000;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    chk("R1", busy == 0, $sformatf("act busy=%0b exp 0 with done", busy));
    cmp("R1");
    @(negedge clk);
    chk("R1", done == 0, $sformatf("act done=%0b exp 0", done));

    // R10: outputs hold after done while inputs move
    hn = n_out; hf = synth_khz;
    target_khz = 18'd12345; max_m = 4'd2;
    repeat (20) @(negedge clk);
    chk("R10", n_out == hn && synth_khz == hf,
        $sformatf("act n=%0d f=%0d exp n=%0d f=%0d", n_out, synth_khz, hn, hf));

    // R2: empty M range
    min_m = 4'd3; max_m = 4'd2;
    search(50000, "R2");
    min_m = 4'd1; max_m = 4'd4;

    // R9: N ceiling too low to reach the target within tolerance
    max_n = 9'd10;
    search(108000, "R9");
    chk("R9", fail == 1, $sformatf("act fail=%0b exp 1", fail));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule